// File: doc/BRIEF.md
# Seven-to-One Pixel Word Serializer

This block accepts one 28-bit pixel word per pixel clock and sends it out over four serial data lanes at seven bits per lane per pixel period. A fifth lane carries a forwarded clock that frames each seven-bit slot. The word holds the colour bits, the data-enable, vertical-sync and horizontal-sync flags, and one spare bit. The integrator chooses where each of these sits in the word. The bit clock runs at seven times the pixel rate and comes from outside the block, which has no frequency synthesis of its own.

Three static configuration inputs shape the behaviour:
- A capture-edge select chooses whether the word is latched on the rising or the falling pixel clock edge.
- An 18-bit mode input removes the top data lane. That lane is released to high impedance and its input bits are dropped.
- An active-low power-down input forces every lane, the clock lane included, to a driven-low state and halts the bit-clock state machine. Power-down wins over the 18-bit release.

After power-down ends, the outputs stay low until the bit-clock phase has been seen to line up with the pixel clock for one complete pixel period.

Top module: `pixelSerializer`

## Requirements
- R1: While rstN is low, and after reset until pdN has been sampled high, every data lane and the clock lane output 0 and every laneOe bit is 1.
- R2: Data lane l sends word bits [7l+6:7l], the highest bit of that slice first, one bit per bitClk rising edge. A new word is loaded on the second bitClk rising edge after a pixClk rising edge, and words follow back to back with no gap.
- R3: While locked, clkLane shows 1,1,1,1,0,0,0 over the seven bit times that begin at each load, so it rises with the first bit of every frame.
- R4: With edgeSel=1 the word on pixWord at a pixClk rising edge is the one loaded at the next load. With edgeSel=0 the word latched at a pixClk falling edge is the one loaded at the load after that falling edge.
- R5: With mode18=1 and power-down inactive, laneOe[3] is 0 and laneData[3] is 0 whatever pixWord[27:21] holds. Lanes 0 to 2 behave as in R2.
- R6: One bitClk rising edge after pdN is sampled 0, all laneData bits and clkLane are 0 and all laneOe bits are 1, including lane 3 in 18-bit mode.
- R7: After pdN returns to 1, the first pixClk rise detected only aligns the phase counter, and all lanes and clkLane stay 0 for that frame. Output starts with the frame loaded at the next detected rise, which must land on the last phase (6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Bit clock at seven times the pixel rate |
| pixClk | input | 1 | Pixel clock, phase-related to bitClk |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Active-low power-down |
| edgeSel | input | 1 | 1: latch on pixClk rising edge, 0: on falling edge |
| mode18 | input | 1 | 1: three data lanes, top lane released |
| pixWord | input | 28 | Parallel pixel word |
| laneData | output | 4 | Serial bit of each data lane |
| laneOe | output | 4 | Drive enable of each data lane (0 = high impedance) |
| clkLane | output | 1 | Forwarded clock lane |

## Verification
Timing is measured from a pixClk rise at time t. The pixClk sampler registers the rise at the first bitClk edge after t, and the shift registers load at the second. Bit j of each lane is therefore valid from load + j bit periods, and the bench reads it at the bitClk falling edge that follows. In rising-capture mode a word applied during pixel period n comes out in period n+1. In falling-capture mode, a word changed after the falling edge comes out in period n+2. The bench drives each word between the falling edge and the next rising edge, so that the two capture edges give different answers. It deframes all five lanes from fixed offsets of every pixel period and expects zeros for the single frame after power-down release.

// File: rtl/pixSerPkg.sv
package pixSerPkg;
  // strobes from the control path into the datapath
  typedef struct packed {
    logic load;   // transfer captured word into the lane shifters
    logic clear;  // power-down: empty the shifters
    logic drive;  // phase locked: let shifter bits reach the lanes
  } serStrobe_t;
endpackage

// File: rtl/pixSerCtrl.sv
module pixSerCtrl
  import pixSerPkg::*;
#(
  parameter int BITS = 7
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       pixClk,
  input  logic       pdN,
  output serStrobe_t strobe
);
  localparam int PH_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(BITS - 1);

  logic pdDown, pixSync, pixSyncD, riseDet;
  logic synced, locked;
  logic [PH_W-1:0] phase;

  assign riseDet = pixSync & ~pixSyncD;

  // power-down state and pixel clock sampler run even while powered down
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      pdDown   <= 1'b1;
      pixSync  <= 1'b0;
      pixSyncD <= 1'b0;
    end else begin
      pdDown   <= ~pdN;
      pixSync  <= pixClk;
      pixSyncD <= pixSync;
    end
  end

  // phase counter: first rise only aligns, second rise on last phase locks
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      synced <= 1'b0;
      locked <= 1'b0;
    end else if (pdDown) begin
      phase  <= '0;
      synced <= 1'b0;
      locked <= 1'b0;
    end else if (riseDet) begin
      phase  <= '0;
      synced <= 1'b1;
      locked <= synced && (phase == LAST);
    end else begin
      phase  <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign strobe.load  = riseDet & ~pdDown;
  assign strobe.clear = pdDown;
  assign strobe.drive = locked & ~pdDown;

  // R7: a locked counter sees each pixel rise exactly at its last phase
  a_r7_phase_aligned: assert property (@(posedge bitClk) disable iff (!rstN)
    (locked && riseDet) |-> (phase == LAST));

  // R7: the rise that first aligns the counter never locks it
  a_r7_no_lock_on_first_rise: assert property (@(posedge bitClk) disable iff (!rstN)
    (synced && !$past(synced)) |-> !locked);

  // R6: power-down drops the lock on the following edge
  a_r6_pd_unlocks: assert property (@(posedge bitClk) disable iff (!rstN)
    pdDown |=> !locked);
endmodule

// File: rtl/pixSerDatapath.sv
module pixSerDatapath
  import pixSerPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int BITS      = 7,
  parameter int CLK_HIGH  = 4,
  parameter int WORD_W    = NUM_LANES * BITS
) (
  input  logic                 pixClk,
  input  logic                 bitClk,
  input  logic                 rstN,
  input  logic                 edgeSel,
  input  logic                 mode18,
  input  logic [WORD_W-1:0]    pixWord,
  input  serStrobe_t           strobe,
  output logic [NUM_LANES-1:0] laneData,
  output logic                 clkLane
);
  localparam logic [BITS-1:0] CLK_PATTERN =
    BITS'(((1 << CLK_HIGH) - 1) << (BITS - CLK_HIGH));

  logic [WORD_W-1:0] capRise, capFall, capSel;
  logic [BITS-1:0]   clkSr;

  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) capRise <= '0;
    else       capRise <= pixWord;
  end

  always_ff @(negedge pixClk or negedge rstN) begin
    if (!rstN) capFall <= '0;
    else       capFall <= pixWord;
  end

  assign capSel = edgeSel ? capRise : capFall;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [BITS-1:0] sr;
    logic            dropLane;
    assign dropLane = mode18 && (l == NUM_LANES - 1);

    always_ff @(posedge bitClk or negedge rstN) begin
      if (!rstN)             sr <= '0;
      else if (strobe.clear) sr <= '0;
      else if (strobe.load)  sr <= dropLane ? '0 : capSel[l*BITS +: BITS];
      else                   sr <= {sr[BITS-2:0], 1'b0};
    end

    assign laneData[l] = strobe.drive & ~dropLane & sr[BITS-1];
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)             clkSr <= '0;
    else if (strobe.clear) clkSr <= '0;
    else if (strobe.load)  clkSr <= CLK_PATTERN;
    else                   clkSr <= {clkSr[BITS-2:0], 1'b0};
  end

  assign clkLane = strobe.drive & clkSr[BITS-1];

  // R3: every frame starts with the clock lane high
  a_r3_clk_frame_high: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.load |=> clkSr[BITS-1]);

  // R5: the dropped lane never holds data loaded in 18-bit mode
  a_r5_top_lane_empty: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobe.load && mode18) |=> (g_lane[NUM_LANES-1].sr == '0));
endmodule

// File: rtl/pixelSerializer.sv
module pixelSerializer
  import pixSerPkg::*;
#(
  parameter int NUM_LANES     = 4,
  parameter int BITS_PER_LANE = 7,
  parameter int CLK_HIGH_BITS = 4,
  parameter int WORD_W        = NUM_LANES * BITS_PER_LANE
) (
  input  logic                 bitClk,
  input  logic                 pixClk,
  input  logic                 rstN,
  input  logic                 pdN,
  input  logic                 edgeSel,
  input  logic                 mode18,
  input  logic [WORD_W-1:0]    pixWord,
  output logic [NUM_LANES-1:0] laneData,
  output logic [NUM_LANES-1:0] laneOe,
  output logic                 clkLane
);
  serStrobe_t strobe;

  pixSerCtrl #(.BITS(BITS_PER_LANE)) i_ctrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .pixClk (pixClk),
    .pdN    (pdN),
    .strobe (strobe)
  );

  pixSerDatapath #(
    .NUM_LANES (NUM_LANES),
    .BITS      (BITS_PER_LANE),
    .CLK_HIGH  (CLK_HIGH_BITS),
    .WORD_W    (WORD_W)
  ) i_dp (
    .pixClk   (pixClk),
    .bitClk   (bitClk),
    .rstN     (rstN),
    .edgeSel  (edgeSel),
    .mode18   (mode18),
    .pixWord  (pixWord),
    .strobe   (strobe),
    .laneData (laneData),
    .clkLane  (clkLane)
  );

  // power-down overrides the release of the top lane
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_oe
    if (l == NUM_LANES - 1) begin : g_top
      assign laneOe[l] = strobe.clear | ~mode18;
    end else begin : g_low
      assign laneOe[l] = 1'b1;
    end
  end

  // R6: one edge after power-down is requested, everything is driven low
  a_r6_pd_driven_low: assert property (@(posedge bitClk) disable iff (!rstN)
    !pdN |=> (laneData == '0 && !clkLane && (&laneOe)));

  // R5: in 18-bit mode while running, the top lane is released and quiet
  a_r5_top_lane_released: assert property (@(posedge bitClk) disable iff (!rstN)
    (mode18 && pdN && $past(pdN)) |-> (!laneOe[NUM_LANES-1] && !laneData[NUM_LANES-1]));
endmodule

// File: tb/test_pixelSerializer.sv
module test_pixelSerializer;
  localparam int BIT_PERIOD = 10;
  localparam int PIX        = 7 * BIT_PERIOD;
  localparam int NPIX       = 12;

  logic        bitClk, pixClk, rstN, pdN, edgeSel, mode18;
  logic [27:0] pixWord;
  logic [3:0]  laneData, laneOe;
  logic        clkLane;
  int          checks = 0;
  int          errors = 0;

  pixelSerializer i_pixelSerializer (
    .bitClk   (bitClk),
    .pixClk   (pixClk),
    .rstN     (rstN),
    .pdN      (pdN),
    .edgeSel  (edgeSel),
    .mode18   (mode18),
    .pixWord  (pixWord),
    .laneData (laneData),
    .laneOe   (laneOe),
    .clkLane  (clkLane)
  );

  // bitClk rises at 5 + 10k; pixClk rises at 70k, falls at 70k + 40
  initial begin
    bitClk = 1'b0;
    forever #(BIT_PERIOD / 2) bitClk = ~bitClk;
  end

  initial begin
    pixClk = 1'b1;
    forever begin
      #(4 * BIT_PERIOD) pixClk = 1'b0;
      #(3 * BIT_PERIOD) pixClk = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [27:0] mkWord(input int n, input int seed);
    case (n % 5)
      0:       return 28'hFFF_FFFF;
      1:       return 28'h000_0000;
      2:       return 28'h1 << ((n + seed) % 28);
      3:       return 28'h555_5555 ^ 28'(seed * 32'h0013_579B);
      default: return 28'((n + 1) * 32'h9E37_79B1 + seed * 32'h85EB_CA6B);
    endcase
  endfunction

  task automatic waitBase();
    int d;
    d = int'($time % PIX);
    if (d != 0) #(PIX - d);
  endtask

  task automatic runStream(input logic e, input logic m18, input int seed);
    logic [27:0] dArr [0:NPIX];
    logic [6:0]  got [0:3];
    logic [6:0]  gotClk;
    logic [27:0] w;
    logic [6:0]  expLane;
    string       tag;
    pdN = 1'b0; edgeSel = e; mode18 = m18;
    waitBase();
    #(PIX);
    #55; dArr[0] = mkWord(0, seed); pixWord = dArr[0];
    #5 pdN = 1'b1;
    #30;
    for (int m = 1; m <= NPIX; m++) begin
      for (int l = 0; l < 4; l++) got[l] = '0;
      gotClk = '0;
      for (int k = 0; k < 7; k++) begin
        for (int l = 0; l < 4; l++) got[l] = {got[l][5:0], laneData[l]};
        gotClk = {gotClk[5:0], clkLane};
        if (k == 3) begin
          #5; dArr[m] = mkWord(m, seed); pixWord = dArr[m]; #5;
        end else begin
          #10;
        end
      end
      if (m == 1) begin
        // R7: first rise after release only aligns
        check(gotClk == 7'b0, "R7 clock lane before lock", 32'(gotClk), 32'h0);
        for (int l = 0; l < 4; l++)
          check(got[l] == 7'b0, "R7 data lane before lock", 32'(got[l]), 32'h0);
      end else begin
        check(gotClk == 7'b1111000, "R3 clock lane frame", 32'(gotClk), 32'h78);
        w = e ? dArr[m - 1] : dArr[m - 2];
        for (int l = 0; l < 4; l++) begin
          expLane = (m18 && l == 3) ? 7'b0 : w[l*7 +: 7];
          tag = (m18 && l == 3) ? "R5 dropped lane quiet" :
                (e ? "R2 rising capture lane" : "R4 falling capture lane");
          check(got[l] == expLane, tag, 32'(got[l]), 32'(expLane));
        end
      end
      check(laneOe == (m18 ? 4'b0111 : 4'b1111), "R5 lane enables",
            32'(laneOe), m18 ? 32'h7 : 32'hF);
    end
    // R6: power-down while running (we are 20 after a pixel rise)
    pdN = 1'b0;
    #10;
    check(laneData == 4'b0, "R6 data lanes low", 32'(laneData), 32'h0);
    check(clkLane == 1'b0, "R6 clock lane low", 32'(clkLane), 32'h0);
    check(laneOe == 4'b1111, "R6 enables override", 32'(laneOe), 32'hF);
  endtask

  initial begin
    rstN = 1'b0; pdN = 1'b1; edgeSel = 1'b1; mode18 = 1'b1; pixWord = '0;
    #20;
    // R1: reset state is the powered-down, driven-low state
    check(laneData == 4'b0, "R1 reset data lanes", 32'(laneData), 32'h0);
    check(clkLane == 1'b0, "R1 reset clock lane", 32'(clkLane), 32'h0);
    check(laneOe == 4'b1111, "R1 reset enables", 32'(laneOe), 32'hF);
    #12 rstN = 1'b1;
    runStream(1'b1, 1'b0, 3);
    runStream(1'b0, 1'b0, 7);
    runStream(1'b1, 1'b1, 11);
    runStream(1'b0, 1'b1, 19);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PIX * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule